// File: doc/BRIEF.md
# Traffic Signal Lamp Fault Monitor

This block watches the lamp drives of the four signal heads at a crossing of two streets. Each head has active-high red, green and yellow lines, which gives twelve inputs in all. On each rising clock edge the lamp lines are loaded into an input register. The registered lamps then pass through three combinational stages.

The first stage encodes each head as a 2-bit state code. The second stage merges the two heads that face the same street into one direction code. The third stage decides whether the two direction states may legally be shown together, and drives an active-low fault line.

A two-state monitor machine follows the fault line. It has the states WATCH and LATCHED. The transition WATCH to LATCHED is taken on the first fault that is seen. The transition LATCHED to WATCH is taken only on a synchronous clear, and clear takes priority in both states. The per-head codes and the direction codes are brought out so that a fault can be traced to the head or the street that caused it.

Top module: `tlf_monitor`

## Requirements
- R1: Head h (h = 0..3) drives lamps[3h] as red, lamps[3h+1] as green and lamps[3h+2] as yellow. The lamps are captured on every rising edge of clk, and all outputs reflect the captured value after that edge.
- R2: head_code[2h+1:2h] is 01 when only red is lit, 10 when only green is lit and 11 when only yellow is lit. When no lamp is lit, or when two or more lamps are lit, the code is 00 (head fault).
- R3: dir_code[1:0] merges heads 0 and 1, and dir_code[3:2] merges heads 2 and 3. A direction code equals the shared head code when the two head codes are equal and nonzero. Otherwise it is 00.
- R4: fault_n is high exactly when one direction code is 01 (red) and the other is 10 (green) or 11 (yellow).
- R5: fault_n is low for every other pair of direction codes. This includes any 00 code, both red, both green, both yellow, and green paired with yellow.
- R6: In state WATCH, a low fault_n with clr low moves the monitor to LATCHED at the next edge. sticky_fault is high exactly in LATCHED.
- R7: In state LATCHED, sticky_fault stays high while clr is low, whatever the lamps show.
- R8: clr high at an edge puts the monitor in WATCH, so sticky_fault is low after that edge. This holds even when fault_n is low in the same cycle.
- R9: An asynchronous low rst_n loads the input register with heads 0 and 1 red and heads 2 and 3 green (lamps value 0x489), and puts the monitor in WATCH. During reset: fault_n = 1, sticky_fault = 0, head_code = 0xA5, dir_code = 0x9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the latched fault |
| lamps | input | 12 | Red, green and yellow lamp lines of the four heads |
| fault_n | output | 1 | Low while the registered lamps form a fault |
| sticky_fault | output | 1 | High from the first fault until a clear |
| head_code | output | 8 | Four 2-bit head state codes |
| dir_code | output | 4 | Two 2-bit direction state codes |

## Verification
The hardest case to reach from the ports is the latch-and-clear sequence. A fault in one cycle must set sticky_fault one cycle later. It must then hold across clean cycles, and clear must win when it arrives together with a fresh fault. A full sweep of the 4096 lamp patterns gives only a handful of valid crossings, so on its own it would leave the monitor latched almost all of the time. The bench therefore pulses clr on a fixed stride throughout the sweep, and then plays a directed sequence of the form fault, clean, clean, clear-with-fault, clear-clean. Every clear-and-latch transition is compared against a cycle-accurate model of the monitor.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
    localparam int HEADS      = 4;
    localparam int LAMPS      = 3;
    localparam int CODE_W     = 2;
    localparam int DIRS       = HEADS / 2;
    localparam int LAMP_BITS  = HEADS * LAMPS;
    localparam int HCODE_BITS = HEADS * CODE_W;
    localparam int DCODE_BITS = DIRS * CODE_W;

    typedef enum logic [CODE_W-1:0] {
        HC_FAULT  = 2'b00,
        HC_RED    = 2'b01,
        HC_GREEN  = 2'b10,
        HC_YELLOW = 2'b11
    } head_code_t;

    typedef enum logic {
        MON_WATCH   = 1'b0,
        MON_LATCHED = 1'b1
    } mon_state_t;

    // Reset lamp image: heads 0,1 red, heads 2,3 green
    localparam logic [LAMP_BITS-1:0] LAMP_RESET = 12'h489;
endpackage

// File: rtl/tlf_head_check.sv
module tlf_head_check
    import tlf_pkg::*;
(
    input  logic [LAMPS-1:0]  lamp,   // {yellow, green, red}
    output logic [CODE_W-1:0] code
);
    always_comb begin
        unique case (lamp)
            3'b001:  code = HC_RED;
            3'b010:  code = HC_GREEN;
            3'b100:  code = HC_YELLOW;
            default: code = HC_FAULT;
        endcase
    end
endmodule

// File: rtl/tlf_dir_merge.sv
module tlf_dir_merge
    import tlf_pkg::*;
(
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] code_dir
);
    always_comb begin
        if (code_a == code_b && code_a != HC_FAULT)
            code_dir = code_a;
        else
            code_dir = HC_FAULT;
    end
endmodule

// File: rtl/tlf_cross_check.sv
module tlf_cross_check
    import tlf_pkg::*;
(
    input  logic [CODE_W-1:0] dir_a,
    input  logic [CODE_W-1:0] dir_b,
    output logic              ok
);
    logic a_red, b_red, a_go, b_go;

    always_comb begin
        a_red = (dir_a == HC_RED);
        b_red = (dir_b == HC_RED);
        a_go  = (dir_a == HC_GREEN) || (dir_a == HC_YELLOW);
        b_go  = (dir_b == HC_GREEN) || (dir_b == HC_YELLOW);
        ok    = (a_red && b_go) || (b_red && a_go);
    end
endmodule

// File: rtl/tlf_monitor.sv
module tlf_monitor
    import tlf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [LAMP_BITS-1:0]  lamps,
    output logic                  fault_n,
    output logic                  sticky_fault,
    output logic [HCODE_BITS-1:0] head_code,
    output logic [DCODE_BITS-1:0] dir_code
);
    logic [LAMP_BITS-1:0] lamp_q;
    mon_state_t           state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lamp_q <= LAMP_RESET;
        else        lamp_q <= lamps;
    end

    genvar h;
    generate
        for (h = 0; h < HEADS; h++) begin : g_head
            tlf_head_check u_head (
                .lamp (lamp_q[h*LAMPS +: LAMPS]),
                .code (head_code[h*CODE_W +: CODE_W])
            );
        end
        for (h = 0; h < DIRS; h++) begin : g_dir
            tlf_dir_merge u_dir (
                .code_a   (head_code[(2*h)*CODE_W   +: CODE_W]),
                .code_b   (head_code[(2*h+1)*CODE_W +: CODE_W]),
                .code_dir (dir_code[h*CODE_W +: CODE_W])
            );
        end
    endgenerate

    tlf_cross_check u_cross (
        .dir_a (dir_code[CODE_W-1:0]),
        .dir_b (dir_code[2*CODE_W-1:CODE_W]),
        .ok    (fault_n)
    );

    // Monitor state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_WATCH;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_WATCH:   if (clr) state_d = MON_WATCH;
                         else if (!fault_n) state_d = MON_LATCHED;
            MON_LATCHED: if (clr) state_d = MON_WATCH;
            default:     state_d = MON_WATCH;
        endcase
        sticky_fault = (state_q == MON_LATCHED);
    end

    generate
        for (h = 0; h < HEADS; h++) begin : g_head_chk
            p_one_lamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (head_code[h*CODE_W +: CODE_W] != HC_FAULT) |->
                ($countones(lamp_q[h*LAMPS +: LAMPS]) == 1));
        end
        for (h = 0; h < DIRS; h++) begin : g_dir_chk
            p_pair_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (dir_code[h*CODE_W +: CODE_W] != HC_FAULT) |->
                (head_code[(2*h)*CODE_W +: CODE_W] == head_code[(2*h+1)*CODE_W +: CODE_W]));
        end
    endgenerate

    p_ok_has_red_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n |-> ($countones({dir_code[1:0] == HC_RED, dir_code[3:2] == HC_RED}) == 1
                     && dir_code[1:0] != HC_FAULT && dir_code[3:2] != HC_FAULT));
    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !clr) |=> sticky_fault);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_fault && !clr) |=> sticky_fault);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sticky_fault);
endmodule

// File: tb/tb_tlf_monitor.sv
module tb_tlf_monitor;
    import tlf_pkg::*;

    typedef struct {
        int          stamp;
        logic [11:0] lamps;
        logic        clr;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [11:0] lamps = 12'h489;
    logic        fault_n, sticky_fault;
    logic [7:0]  head_code;
    logic [3:0]  dir_code;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    item_t sb_q[$];

    tlf_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .lamps(lamps),
        .fault_n(fault_n), .sticky_fault(sticky_fault),
        .head_code(head_code), .dir_code(dir_code)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model from the fault definitions
    function automatic logic [1:0] ref_head(input logic [2:0] l);
        int lit = l[0] + l[1] + l[2];
        if (lit != 1) return 2'b00;
        if (l[0]) return 2'b01;
        if (l[1]) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [1:0] ref_dir(input logic [1:0] a, input logic [1:0] b);
        return (a != b || a == 2'b00) ? 2'b00 : a;
    endfunction

    function automatic logic ref_ok(input logic [1:0] a, input logic [1:0] b);
        case ({a, b})
            4'b0110, 4'b0111, 4'b1001, 4'b1101: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit good, input string tag, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [11:0] v, input logic c);
        item_t it;
        @(negedge clk);
        lamps = v;
        clr   = c;
        it.stamp = cyc;
        it.lamps = v;
        it.clr   = c;
        sb_q.push_back(it);
    endtask

    // Monitor / scoreboard
    logic model_sticky = 1'b0;
    logic prev_ok = 1'b1;
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
            item_t it;
            logic [7:0] eh;
            logic [3:0] ed;
            logic       eok;
            it = sb_q.pop_front();
            for (int h = 0; h < 4; h++) eh[2*h +: 2] = ref_head(it.lamps[3*h +: 3]);
            ed[1:0] = ref_dir(eh[1:0], eh[3:2]);
            ed[3:2] = ref_dir(eh[5:4], eh[7:6]);
            eok = ref_ok(ed[1:0], ed[3:2]);
            check(head_code == eh, "R1 R2 head_code", head_code, eh);
            check(dir_code == ed, "R3 dir_code", dir_code, ed);
            check(fault_n == eok, eok ? "R4 fault_n" : "R5 fault_n", fault_n, eok);
            if (it.clr) begin
                model_sticky = 1'b0;
                check(sticky_fault == model_sticky, "R8 sticky_fault", sticky_fault, model_sticky);
            end else if (model_sticky) begin
                check(sticky_fault == 1'b1, "R7 sticky_fault", sticky_fault, 1);
            end else begin
                model_sticky = !prev_ok;
                check(sticky_fault == model_sticky, "R6 sticky_fault", sticky_fault, model_sticky);
            end
            prev_ok = eok;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(fault_n == 1'b1, "R9 fault_n", fault_n, 1);
        check(sticky_fault == 1'b0, "R9 sticky_fault", sticky_fault, 0);
        check(head_code == 8'hA5, "R9 head_code", head_code, 8'hA5);
        check(dir_code == 4'h9, "R9 dir_code", dir_code, 4'h9);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int v = 0; v < 4096; v++) send(v[11:0], (v % 7) == 3);
        // Directed latch / hold / clear sequence
        send(12'h489, 1'b1);
        send(12'h000, 1'b0);
        send(12'h489, 1'b0);
        send(12'h264, 1'b0);
        send(12'h000, 1'b1);
        send(12'h489, 1'b0);
        send(12'h489, 1'b1);
        send(12'h264, 1'b0);
        send(12'h489, 1'b0);
        send(12'hFFF, 1'b0);
        send(12'h489, 1'b0);
        send(12'h489, 1'b1);
        send(12'h489, 1'b0);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule